// File: doc/BRIEF.md
# Error Interrupt Aggregator with Doorbell

This block gathers up to 64 system error sources into one summary interrupt line for a parent interrupt controller. The lowest sources are level-sensitive wires driven by neighbouring logic. The rest are message sources: an agent raises one by writing its index to a doorbell word on the block's register bus. Both kinds land in a single shared cause space. A matching mask space selects which pending causes drive the summary line.

Software uses a plain 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Each 32-bit word of the cause space holds 32 sources. A cause bit is cleared by writing 1 to it. A mask bit of 1 blocks its source from the summary line. How many sources are wired and how many are message-driven is set by a parameter. The default is 21 wired and 43 message sources.

Top module: `err_irq_aggregator`

## Requirements
- R1: After reset every cause bit reads 0, every mask bit reads 1 and `irq_out` is low.
- R2: Source n is held in word n/32 at bit n%32. Cause words are read at byte offsets 0x00 and 0x04. Mask words are read at byte offsets 0x20 and 0x24.
- R3: Writing a cause word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFFFFFF to both cause words empties the whole cause space.
- R4: A write to a mask word replaces all 32 mask bits. A mask bit of 1 disables its source and a mask bit of 0 enables it.
- R5: A wired source (index below NUM_WIRED, default 21) sets its cause bit on every rising clock edge at which its input is high. A cleared bit therefore comes back one cycle later while the input stays high.
- R6: A bus write of value n to byte offset 0x30 sets cause bit n on the next clock edge, for NUM_WIRED <= n < 64.
- R7: A doorbell value of 64 or more, or a value below NUM_WIRED, changes no cause bit.
- R8: When a set and a software clear reach the same cause bit in one cycle, the bit ends up set.
- R9: `irq_out` is high exactly one cycle after a cycle in which some cause bit is 1 and its mask bit is 0. Otherwise it is low.
- R10: Reads of offset 0x30 and of any offset not listed in R2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wired_in | input | NUM_WIRED | Level-high error inputs for the low sources |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; for the doorbell it is a source index |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A corrupt cause or mask bit reaches the ports in one of two ways. It shows in `irq_out` one cycle later, as soon as that bit is both pending and enabled. It also shows in the same cycle on `bus_rdata` whenever its word is addressed. The bench keeps its own model of the cause and mask spaces and compares `irq_out` with it on every cycle. It reads back both word types after every stimulus that matters, so a lost doorbell, a clear that spills into another bit, or a wired bit that fails to return is caught within a cycle or two. The cases it drives include doorbell indices at the wired/message boundary and out of range, clears while a wired input is still high, and a partial mask.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned CAUSE_OFS    = 'h00;
  localparam int unsigned MASK_OFS     = 'h20;
  localparam int unsigned DOORBELL_OFS = 'h30;
endpackage

// File: rtl/eia_rst_sync.sv
module eia_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/eia_reg_decode.sv
module eia_reg_decode
  import eia_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [NUM_SRC-1:0]   cause_clr,
  output logic [NUM_SRC-1:0]   db_set,
  output logic [NUM_WORDS-1:0] mask_we
);
  logic db_hit;
  assign db_hit = bus_wr && (bus_addr == ADDR_W'(DOORBELL_OFS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic cause_hit;
    assign cause_hit = bus_wr && (bus_addr == ADDR_W'(CAUSE_OFS + 4 * w));
    assign cause_clr[w*WORD_W +: WORD_W] = cause_hit ? bus_wdata : '0;
    assign mask_we[w] = bus_wr && (bus_addr == ADDR_W'(MASK_OFS + 4 * w));
  end

  // Only message sources may be raised through the doorbell.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_db
    if (n < NUM_WIRED) begin : g_wired
      assign db_set[n] = 1'b0;
    end else begin : g_msg
      assign db_set[n] = db_hit && (bus_wdata == WORD_W'(n));
    end
  end
endmodule

// File: rtl/eia_source_bank.sv
module eia_source_bank
  import eia_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21,
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired_in,
  input  logic [NUM_SRC-1:0]   cause_clr,
  input  logic [NUM_SRC-1:0]   db_set,
  input  logic [NUM_WORDS-1:0] mask_we,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [NUM_SRC-1:0]   cause_q,
  output logic [NUM_SRC-1:0]   mask_q
);
  logic [NUM_SRC-1:0] lvl_set;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] cause_d;
  logic [NUM_SRC-1:0] mask_d;
  logic               cause_en;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_lvl
    if (n < NUM_WIRED) begin : g_w
      assign lvl_set[n] = wired_in[n];
    end else begin : g_m
      assign lvl_set[n] = 1'b0;
    end
  end

  assign set_vec  = lvl_set | db_set;
  assign cause_en = (|cause_clr) | (|set_vec);

  // Clear first, then set: a set in the same cycle always survives.
  always_comb begin
    cause_d = (cause_q & ~cause_clr) | set_vec;
  end

  always_comb begin
    mask_d = mask_q;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (mask_we[w]) mask_d[w*WORD_W +: WORD_W] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (|mask_we)  mask_q <= mask_d;
  end
endmodule

// File: rtl/eia_summary.sv
module eia_summary #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] cause_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic               irq_out
);
  logic pend_d;
  logic irq_q;

  assign pend_d = |(cause_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_d;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/err_irq_aggregator.sv
module err_irq_aggregator
  import eia_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] wired_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 irq_out
);
  localparam int unsigned NUM_WORDS = NUM_SRC / WORD_W;

  logic                 rst_int_n;
  logic [NUM_SRC-1:0]   cause_clr;
  logic [NUM_SRC-1:0]   db_set;
  logic [NUM_WORDS-1:0] mask_we;
  logic [NUM_SRC-1:0]   cause_q;
  logic [NUM_SRC-1:0]   mask_q;

  eia_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  eia_reg_decode #(
    .NUM_SRC   (NUM_SRC),
    .NUM_WIRED (NUM_WIRED),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cause_clr (cause_clr),
    .db_set    (db_set),
    .mask_we   (mask_we)
  );

  eia_source_bank #(
    .NUM_SRC   (NUM_SRC),
    .NUM_WIRED (NUM_WIRED)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wired_in  (wired_in),
    .cause_clr (cause_clr),
    .db_set    (db_set),
    .mask_we   (mask_we),
    .bus_wdata (bus_wdata),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
  );

  eia_summary #(
    .NUM_SRC (NUM_SRC)
  ) u_sum (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq_out (irq_out)
  );

  // Read mux: the doorbell and unmapped offsets fall through to zero.
  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(CAUSE_OFS + 4 * w)) bus_rdata = cause_q[w*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(MASK_OFS + 4 * w))  bus_rdata = mask_q[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/eia_checker.sv
module eia_checker
  import eia_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic [NUM_WIRED-1:0] wired_in,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [WORD_W-1:0]    bus_wdata,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic [NUM_SRC-1:0]   cause_q,
  input logic [NUM_SRC-1:0]   mask_q,
  input logic                 irq_out
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed_q <= 1'b0;
    else            armed_q <= 1'b1;
  end

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (!armed_q)
    1'b1 |=> (irq_out == $past(|(cause_q & ~mask_q))));

  // R5
  wired_latch_chk: assert property (@(posedge clk) disable iff (!armed_q)
    1'b1 |=> ((cause_q[NUM_WIRED-1:0] & $past(wired_in)) == $past(wired_in)));

  // R6
  doorbell_set_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (bus_wr && bus_addr == ADDR_W'(DOORBELL_OFS) &&
     bus_wdata >= WORD_W'(NUM_WIRED) && bus_wdata < WORD_W'(NUM_SRC))
    |=> cause_q[$past(bus_wdata[IDX_W-1:0])]);

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (bus_wr && bus_addr == ADDR_W'(MASK_OFS))
    |=> (mask_q[WORD_W-1:0] == $past(bus_wdata)));

  // R10
  doorbell_read_zero_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (bus_addr == ADDR_W'(DOORBELL_OFS)) |-> (bus_rdata == '0));

  if (NUM_WIRED < WORD_W) begin : g_w1c
    // R3
    cause_w1c_chk: assert property (@(posedge clk) disable iff (!armed_q)
      (bus_wr && bus_addr == ADDR_W'(CAUSE_OFS) && bus_wdata[WORD_W-1])
      |=> !cause_q[WORD_W-1]);
  end
endmodule

bind err_irq_aggregator eia_checker #(
  .NUM_SRC   (NUM_SRC),
  .NUM_WIRED (NUM_WIRED),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .wired_in  (wired_in),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .irq_out   (irq_out)
);

// File: tb/test_err_irq_aggregator.sv
`timescale 1ns/1ps
module test_err_irq_aggregator;
  localparam int NSRC = 64;
  localparam int NW   = 21;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] wired;
  logic [7:0]    addr;
  logic          wr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 1'b0;

  bit [NSRC-1:0] m_cause;
  bit [NSRC-1:0] m_mask;
  bit            m_irq;

  always #10 clk = ~clk;

  err_irq_aggregator #(.NUM_SRC(NSRC), .NUM_WIRED(NW), .ADDR_W(8)) i_err_irq_aggregator (
    .clk       (clk),
    .rst_n     (rst_n),
    .wired_in  (wired),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_out   (irq)
  );

  // Behavioural reference, updated on each rising edge from the bench inputs.
  always @(posedge clk) begin
    bit [NSRC-1:0] nc;
    bit [NSRC-1:0] nm;
    if (!rst_n) begin
      m_cause <= '0;
      m_mask  <= '1;
      m_irq   <= 1'b0;
    end else begin
      nc = m_cause;
      nm = m_mask;
      if (wr && addr == 8'h00) nc[31:0]  = nc[31:0]  & ~wdata;
      if (wr && addr == 8'h04) nc[63:32] = nc[63:32] & ~wdata;
      if (wr && addr == 8'h20) nm[31:0]  = wdata;
      if (wr && addr == 8'h24) nm[63:32] = wdata;
      if (wr && addr == 8'h30 && wdata >= NW && wdata < NSRC) nc[wdata] = 1'b1;
      for (int i = 0; i < NW; i++) if (wired[i]) nc[i] = 1'b1;
      m_irq   <= |(m_cause & ~m_mask);
      m_cause <= nc;
      m_mask  <= nm;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_cause[31:0];
      8'h04:   return m_cause[63:32];
      8'h20:   return m_mask[31:0];
      8'h24:   return m_mask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      n_tests++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R9 irq_out actual=%0b expected=%0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic read_chk(input logic [7:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    addr = a;
    #1;
    exp = model_read(a);
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read 0x%02h actual=%08h expected=%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic exp_chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wired = '0; addr = '0; wr = 1'b0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    chk_on = 1'b1;

    // R1: reset state of both spaces
    read_chk(8'h00, "R1");
    exp_chk(rdata, 32'h0, "R1 cause0");
    read_chk(8'h04, "R1");
    read_chk(8'h20, "R1");
    exp_chk(rdata, 32'hFFFF_FFFF, "R1 mask0");
    read_chk(8'h24, "R1");
    exp_chk({31'd0, irq}, 32'h0, "R1 irq");

    // R3: full clear after reset
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    read_chk(8'h00, "R3");
    read_chk(8'h04, "R3");

    // R4: unmask everything
    bus_write(8'h20, 32'h0);
    bus_write(8'h24, 32'h0);
    read_chk(8'h20, "R4");
    read_chk(8'h24, "R4");

    // R5 / R9: one-cycle pulse on a wired input latches
    @(negedge clk); wired[3] = 1'b1;
    @(negedge clk); wired[3] = 1'b0;
    read_chk(8'h00, "R5");
    exp_chk(rdata & 32'h8, 32'h8, "R5 bit3");
    idle(2);
    exp_chk({31'd0, irq}, 32'h1, "R9 irq high");
    bus_write(8'h00, 32'h8);
    idle(2);
    exp_chk({31'd0, irq}, 32'h0, "R9 irq low");

    // R8 / R5: clear while the wired input stays high keeps the bit
    @(negedge clk); wired[5] = 1'b1;
    bus_write(8'h00, 32'h20);
    read_chk(8'h00, "R8");
    exp_chk(rdata & 32'h20, 32'h20, "R8 bit5");
    @(negedge clk); wired[5] = 1'b0;
    bus_write(8'h00, 32'h20);
    read_chk(8'h00, "R5");

    // R6 / R2: doorbell indices at the boundary and in the upper word
    bus_write(8'h30, 32'd21);
    read_chk(8'h00, "R6");
    exp_chk(rdata, 32'h0020_0000, "R6 idx21");
    bus_write(8'h30, 32'd40);
    bus_write(8'h30, 32'd63);
    read_chk(8'h04, "R2");
    exp_chk(rdata, 32'h8000_0100, "R2 idx40/63");

    // R7: out-of-range and wired-index doorbell values are ignored
    bus_write(8'h30, 32'd64);
    bus_write(8'h30, 32'd100);
    bus_write(8'h30, 32'd20);
    bus_write(8'h30, 32'd5);
    read_chk(8'h00, "R7");
    read_chk(8'h04, "R7");

    // R3: zeros leave bits alone, ones clear only their bits
    bus_write(8'h04, 32'h0);
    read_chk(8'h04, "R3");
    bus_write(8'h04, 32'h0000_0100);
    read_chk(8'h04, "R3");
    exp_chk(rdata, 32'h8000_0000, "R3 partial");

    // R4 / R9: mask the remaining pending bits
    bus_write(8'h20, 32'h0020_0000);
    bus_write(8'h24, 32'h8000_0000);
    idle(2);
    exp_chk({31'd0, irq}, 32'h0, "R4 masked");
    bus_write(8'h24, 32'h0);
    idle(2);
    exp_chk({31'd0, irq}, 32'h1, "R4 unmasked");

    // R10: doorbell and unmapped reads
    read_chk(8'h30, "R10");
    read_chk(8'h10, "R10");
    read_chk(8'h2C, "R10");
    exp_chk(rdata, 32'h0, "R10 0x2C");

    // R3: closing full clear
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    read_chk(8'h00, "R3");
    read_chk(8'h04, "R3");
    idle(3);
    exp_chk({31'd0, irq}, 32'h0, "R3 irq after clear");

    chk_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule